// File: doc/BRIEF.md
# Recovered-Clock Lock and Signal-Loss Supervisor

This block is the digital supervisor of a clock-and-data-recovery loop that can run at two line rates. It runs on the local reference clock (nominally 19.44 MHz). It measures the recovered clock by counting its rising edges over a fixed window of reference cycles. The edge count crosses into the reference domain as a Gray code through a two-flop synchronizer. The block then compares the count with a target derived from the rate mode: 32 recovered edges per reference cycle in the fast mode (622.08 Mb/s) and 8 in the slow mode (155.52 Mb/s).

After reset, the loop-source select steers the analog loop onto the reference. Only when the reference-driven loop has measured in tolerance for two windows in a row does the select move to the incoming data. The lock flag rises after two more good windows taken while the loop tracks the data. A single window outside the tolerance (about ±500 ppm) sends the loop back to the reference and drops lock at once. The recovered clock therefore keeps running near the reference frequency.

Two signal-detect pins and a test pin form a loss-of-signal condition. This condition mutes the serial data, holds the lock flag low and keeps the loop on the reference. When the condition clears, or when the rate mode changes, acquisition restarts from the reference phase.

Top module: `cdr_lock_supervisor`

## Requirements
- R1: While reset is high and on the first cycle after it, the block drives lock_o=0, sel_data_o=0 (loop on reference) and mute_o=0, provided both signal-detect pins are high.
- R2: A measurement window is 2^WIN_LOG2 reference cycles. The target count is 2^(WIN_LOG2+5) recovered edges when rate_hi=1 and 2^(WIN_LOG2+3) when rate_hi=0. A window is in tolerance when its count differs from the target by no more than TOL_HI or TOL_LO, chosen by the same mode. A recovered clock at the wrong mode's rate never produces lock.
- R3: After any restart, the first window is discarded. sel_data_o rises to 1 only after two consecutive in-tolerance windows measured while sel_data_o=0.
- R4: lock_o rises only after two consecutive in-tolerance windows measured while sel_data_o=1. lock_o=1 implies sel_data_o=1. lock_o cannot rise while the data-tracking windows keep failing.
- R5: One out-of-tolerance window, with or without lock, clears lock_o and sel_data_o together.
- R6: Loss of signal holds when test_en=0 and at least one of sig_det_a or sig_det_b is 0. Three clock edges after such pin levels settle, mute_o=1, lock_o=0 and sel_data_o=0, and they stay so while the condition lasts.
- R7: While test_en=1, low signal-detect pins have no effect: mute_o stays 0 and an existing lock is kept.
- R8: Three clock edges after the loss-of-signal condition ends, mute_o=0 and lock_o=0. The full acquisition of R3 and R4 then restarts.
- R9: A change on rate_hi clears lock_o and sel_data_o within three clock edges and restarts acquisition in the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local reference clock; all control logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| rate_hi | input | 1 | Rate mode: 1 = 32 recovered edges per reference cycle, 0 = 8 |
| sig_det_a | input | 1 | First signal-detect pin, low means signal missing (asynchronous) |
| sig_det_b | input | 1 | Second signal-detect pin, low means signal missing (asynchronous) |
| test_en | input | 1 | High disables loss-of-signal detection (asynchronous) |
| rec_clk | input | 1 | Recovered clock from the analog loop |
| lock_o | output | 1 | Loop locked to incoming data |
| sel_data_o | output | 1 | Loop source: 1 = incoming data, 0 = local reference |
| mute_o | output | 1 | Mute the serial data output |

## Verification
The checker watches the pin-level relations on every cycle. It checks that lock always implies data tracking and that lock never rises without a data-tracking phase before it. It also checks that a settled loss-of-signal pattern mutes within three edges and that a cleared one unmutes, that mute excludes both lock and data selection, and that a rate toggle drops lock within three edges. The window arithmetic can only be shown by the bench scenarios. These cover the edge-count target in each mode, the tolerance band at its inside and outside, the discarded first window, the two-window debounce in each phase, and recovery after a lock loss or a signal loss. The bench models the loop by making the recovered clock follow the reference or a data clock of chosen period, depending on the select output.

// File: rtl/cdrsup_pkg.sv
`timescale 1ns/10fs
package cdrsup_pkg;

  // Acquisition phases of the supervisor.
  typedef enum logic [1:0] {
    ST_REF  = 2'd0,  // loop steered to local reference
    ST_DATA = 2'd1,  // loop tracking data, lock not yet declared
    ST_LOCK = 2'd2,  // locked to data
    ST_LOS  = 2'd3   // signal lost: muted, held on reference
  } sup_state_t;

endpackage

// File: rtl/cdrsup_sync.sv
`timescale 1ns/10fs
// Two-flop synchronizer into the reference domain.
module cdrsup_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/cdrsup_edge_counter.sv
`timescale 1ns/10fs
// Free-running recovered-clock edge counter with a registered Gray output.
module cdrsup_edge_counter #(
  parameter int CW = 19
) (
  input  logic          rec_clk,
  input  logic          rst,
  output logic [CW-1:0] gray_o
);
  logic          rst_m, rst_r;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;

  // Reset is brought into the recovered domain before use.
  always_ff @(posedge rec_clk) begin
    rst_m <= rst;
    rst_r <= rst_m;
  end

  assign cnt_nxt = cnt + CW'(1);

  always_ff @(posedge rec_clk) begin
    if (rst_r) begin
      cnt    <= '0;
      gray_o <= '0;
    end else begin
      cnt    <= cnt_nxt;
      gray_o <= cnt_nxt ^ (cnt_nxt >> 1);
    end
  end
endmodule

// File: rtl/cdrsup_freq_meter.sv
`timescale 1ns/10fs
// Window timer and tolerance compare in the reference domain.
module cdrsup_freq_meter #(
  parameter int CW       = 19,
  parameter int WIN_LOG2 = 12,
  parameter int NOM_HI   = 131072,
  parameter int NOM_LO   = 32768,
  parameter int TOL_HI   = 66,
  parameter int TOL_LO   = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          rate_hi,
  input  logic [CW-1:0] gray_s,
  output logic          eval_valid,
  output logic          in_tol
);
  localparam logic [CW-1:0] HI_MIN = CW'(NOM_HI - TOL_HI);
  localparam logic [CW-1:0] HI_MAX = CW'(NOM_HI + TOL_HI);
  localparam logic [CW-1:0] LO_MIN = CW'(NOM_LO - TOL_LO);
  localparam logic [CW-1:0] LO_MAX = CW'(NOM_LO + TOL_LO);

  logic [WIN_LOG2-1:0] win_cnt;
  logic                win_end;
  logic                primed;
  logic [CW-1:0]       bin_now;
  logic [CW-1:0]       bin_prev;
  logic [CW-1:0]       delta;
  logic [CW-1:0]       lim_min, lim_max;

  always_comb begin
    bin_now[CW-1] = gray_s[CW-1];
    for (int i = CW - 2; i >= 0; i--) begin
      bin_now[i] = bin_now[i+1] ^ gray_s[i];
    end
  end

  assign win_end = &win_cnt;
  assign delta   = bin_now - bin_prev;
  assign lim_min = rate_hi ? HI_MIN : LO_MIN;
  assign lim_max = rate_hi ? HI_MAX : LO_MAX;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      win_cnt    <= '0;
      primed     <= 1'b0;
      eval_valid <= 1'b0;
      in_tol     <= 1'b0;
      bin_prev   <= bin_now;
    end else begin
      win_cnt    <= win_cnt + WIN_LOG2'(1);
      eval_valid <= win_end && primed;
      if (win_end) begin
        bin_prev <= bin_now;
        primed   <= 1'b1;
        in_tol   <= (delta >= lim_min) && (delta <= lim_max);
      end
    end
  end
endmodule

// File: rtl/cdrsup_seq.sv
`timescale 1ns/10fs
// Acquisition sequencer: reference first, then data, with a debounce of
// GOOD_WINS windows per phase; signal loss and rate changes take priority.
module cdrsup_seq
  import cdrsup_pkg::*;
#(
  parameter int GOOD_WINS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic los,
  input  logic rate_hi,
  input  logic eval_valid,
  input  logic in_tol,
  output logic restart,
  output logic lock_o,
  output logic sel_data_o,
  output logic mute_o
);
  localparam int GCW = (GOOD_WINS > 2) ? $clog2(GOOD_WINS) : 1;

  sup_state_t     state, nxt;
  logic [GCW-1:0] good, good_nxt;
  logic           rate_q;

  always_comb begin
    nxt      = state;
    good_nxt = good;
    restart  = 1'b0;
    if (los) begin
      nxt      = ST_LOS;
      good_nxt = '0;
    end else if (state == ST_LOS || rate_hi != rate_q) begin
      nxt      = ST_REF;
      good_nxt = '0;
      restart  = 1'b1;
    end else if (eval_valid) begin
      if (!in_tol) begin
        nxt      = ST_REF;
        good_nxt = '0;
      end else if (state != ST_LOCK) begin
        if (good == GCW'(GOOD_WINS - 1)) begin
          good_nxt = '0;
          nxt      = (state == ST_REF) ? ST_DATA : ST_LOCK;
        end else begin
          good_nxt = good + GCW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_REF;
      good       <= '0;
      rate_q     <= rate_hi;
      lock_o     <= 1'b0;
      sel_data_o <= 1'b0;
      mute_o     <= 1'b0;
    end else begin
      state      <= nxt;
      good       <= good_nxt;
      rate_q     <= rate_hi;
      lock_o     <= (nxt == ST_LOCK);
      sel_data_o <= (nxt == ST_DATA) || (nxt == ST_LOCK);
      mute_o     <= (nxt == ST_LOS);
    end
  end
endmodule

// File: rtl/cdr_lock_supervisor.sv
`timescale 1ns/10fs
module cdr_lock_supervisor #(
  parameter int WIN_LOG2  = 12,
  parameter int HI_SHIFT  = 5,
  parameter int LO_SHIFT  = 3,
  parameter int TOL_HI    = 66,
  parameter int TOL_LO    = 16,
  parameter int GOOD_WINS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_hi,
  input  logic sig_det_a,
  input  logic sig_det_b,
  input  logic test_en,
  input  logic rec_clk,
  output logic lock_o,
  output logic sel_data_o,
  output logic mute_o
);
  localparam int NOM_HI = 1 << (WIN_LOG2 + HI_SHIFT);
  localparam int NOM_LO = 1 << (WIN_LOG2 + LO_SHIFT);
  localparam int CW     = WIN_LOG2 + HI_SHIFT + 2;

  logic [3:0]    ctl_s;      // {rate, test, det_b, det_a}
  logic          los;
  logic [CW-1:0] gray_rec, gray_s;
  logic          restart, eval_valid, in_tol;

  cdrsup_sync #(.W(4), .RST_VAL(4'b0011)) u_ctl_sync (
    .clk (clk),
    .rst (rst),
    .d   ({rate_hi, test_en, sig_det_b, sig_det_a}),
    .q   (ctl_s)
  );

  assign los = !ctl_s[2] && (!ctl_s[0] || !ctl_s[1]);

  cdrsup_edge_counter #(.CW(CW)) u_edge_cnt (
    .rec_clk (rec_clk),
    .rst     (rst),
    .gray_o  (gray_rec)
  );

  cdrsup_sync #(.W(CW), .RST_VAL('0)) u_gray_sync (
    .clk (clk),
    .rst (rst),
    .d   (gray_rec),
    .q   (gray_s)
  );

  cdrsup_freq_meter #(
    .CW(CW), .WIN_LOG2(WIN_LOG2), .NOM_HI(NOM_HI), .NOM_LO(NOM_LO),
    .TOL_HI(TOL_HI), .TOL_LO(TOL_LO)
  ) u_meter (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .rate_hi    (ctl_s[3]),
    .gray_s     (gray_s),
    .eval_valid (eval_valid),
    .in_tol     (in_tol)
  );

  cdrsup_seq #(.GOOD_WINS(GOOD_WINS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .los        (los),
    .rate_hi    (ctl_s[3]),
    .eval_valid (eval_valid),
    .in_tol     (in_tol),
    .restart    (restart),
    .lock_o     (lock_o),
    .sel_data_o (sel_data_o),
    .mute_o     (mute_o)
  );
endmodule

// File: rtl/cdrsup_checker.sv
`timescale 1ns/10fs
module cdrsup_checker (
  input logic clk,
  input logic rst,
  input logic rate_hi,
  input logic sig_det_a,
  input logic sig_det_b,
  input logic test_en,
  input logic lock_o,
  input logic sel_data_o,
  input logic mute_o
);
  logic los_pin;
  assign los_pin = !test_en && (!sig_det_a || !sig_det_b);

  a_r4_lock_on_data: assert property (@(posedge clk) disable iff (rst)
    lock_o |-> sel_data_o);

  a_r4_lock_after_data: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> $past(sel_data_o));

  a_r3_sel_rise_unlocked: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_data_o) |-> (!lock_o && !mute_o));

  a_r6_mute_exclusive: assert property (@(posedge clk) disable iff (rst)
    mute_o |-> (!lock_o && !sel_data_o));

  a_r6_los_mutes: assert property (@(posedge clk) disable iff (rst)
    (los_pin && $past(los_pin) && $past(los_pin, 2) &&
     !$past(rst) && !$past(rst, 2)) |=> mute_o);

  a_r8_clear_unmutes: assert property (@(posedge clk) disable iff (rst)
    (!los_pin && !$past(los_pin) && !$past(los_pin, 2) &&
     !$past(rst) && !$past(rst, 2)) |=> !mute_o);

  a_r9_rate_drops_lock: assert property (@(posedge clk) disable iff (rst)
    (($past(rate_hi) != $past(rate_hi, 2)) &&
     !$past(rst) && !$past(rst, 2) && !$past(rst, 3)) |-> ##2 !lock_o);
endmodule

bind cdr_lock_supervisor cdrsup_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .rate_hi    (rate_hi),
  .sig_det_a  (sig_det_a),
  .sig_det_b  (sig_det_b),
  .test_en    (test_en),
  .lock_o     (lock_o),
  .sel_data_o (sel_data_o),
  .mute_o     (mute_o)
);

// File: tb/cdr_lock_supervisor_bench.sv
`timescale 1ns/10fs
module cdr_lock_supervisor_bench;
  localparam int W = 64;  // window length with WIN_LOG2 = 6

  logic clk = 1'b0, rst = 1'b1, rate_hi = 1'b1;
  logic sig_det_a = 1'b1, sig_det_b = 1'b1, test_en = 1'b0, rec_clk = 1'b0;
  logic lock_o, sel_data_o, mute_o;
  real  data_per = 0.25;  // period of the data-derived recovered clock, ns

  cdr_lock_supervisor #(.WIN_LOG2(6), .TOL_HI(8), .TOL_LO(2)) u_cdr_lock_supervisor (
    .clk(clk), .rst(rst), .rate_hi(rate_hi), .sig_det_a(sig_det_a),
    .sig_det_b(sig_det_b), .test_en(test_en), .rec_clk(rec_clk),
    .lock_o(lock_o), .sel_data_o(sel_data_o), .mute_o(mute_o)
  );

  always #4 clk = ~clk;

  // Loop model: recovered clock follows the reference rate or the data.
  function automatic real half_per();
    if (sel_data_o === 1'b1) return data_per / 2.0;
    return (rate_hi ? 0.25 : 1.0) / 2.0;
  endfunction
  always begin
    #(half_per());
    rec_clk = ~rec_clk;
  end

  typedef struct {
    logic [2:0] exp;   // {lock, sel, mute}
    logic [2:0] msk;
    string      tag;
  } item_t;
  item_t sb_q[$];
  int n_chk = 0, n_fail = 0, lock_hi_cycles = 0;
  bit done = 0;

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(int after, logic [2:0] exp, logic [2:0] msk, string tag);
    cyc(after);
    sb_q.push_back('{exp, msk, tag});
  endtask

  task automatic check_val(bit ok, int act, int expv, string tag);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Monitor: compares each queued expectation at the following falling edge.
  always @(negedge clk) begin
    if (lock_o === 1'b1) lock_hi_cycles++;
    if (sb_q.size() > 0) begin
      item_t it;
      logic [2:0] got;
      it  = sb_q.pop_front();
      got = {lock_o, sel_data_o, mute_o};
      n_chk++;
      if ((got & it.msk) !== (it.exp & it.msk)) begin
        n_fail++;
        $display("FAIL %s: lock/sel/mute actual %b expected %b (mask %b)",
                 it.tag, got, it.exp, it.msk);
      end
    end
  end

  // Acquisition from a restart that happened 'elapsed' cycles ago.
  task automatic acquire(int elapsed, string tag);
    expect_out(160 - elapsed, 3'b000, 3'b110, {tag, " R3 still on reference"});
    expect_out(128, 3'b010, 3'b110, {tag, " R3 data select, R4 no lock yet"});
    expect_out(64, 3'b110, 3'b111, {tag, " R4 lock declared"});
  endtask

  task automatic no_lock_for(int n, string tag);
    int snap;
    snap = lock_hi_cycles;
    cyc(n);
    check_val(lock_hi_cycles == snap, lock_hi_cycles - snap, 0, tag);
  endtask

  initial begin
    cyc(10);
    expect_out(0, 3'b000, 3'b111, "R1 in reset");
    rst = 1'b0;
    expect_out(1, 3'b000, 3'b111, "R1 after reset");
    acquire(1, "fast start");

    data_per = 0.2504;
    expect_out(3 * W, 3'b110, 3'b110, "R2 inside tolerance keeps lock");
    data_per = 0.252;
    expect_out(2 * W, 3'b000, 3'b110, "R5 outside tolerance drops lock");
    no_lock_for(10 * W, "R4 no lock while data windows fail");
    data_per = 0.25;
    expect_out(7 * W, 3'b100, 3'b100, "R5 relock after recovery");

    sig_det_a = 1'b0;
    expect_out(5, 3'b001, 3'b111, "R6 det_a low mutes");
    expect_out(3 * W, 3'b001, 3'b111, "R6 mute held");
    sig_det_a = 1'b1;
    expect_out(5, 3'b000, 3'b111, "R8 unmute");
    acquire(5, "R8 after signal loss");

    sig_det_b = 1'b0;
    expect_out(5, 3'b001, 3'b111, "R6 det_b low mutes");
    sig_det_b = 1'b1;
    expect_out(7 * W, 3'b100, 3'b101, "R8 relock after det_b");

    test_en = 1'b1;
    sig_det_a = 1'b0;
    expect_out(5, 3'b110, 3'b111, "R7 test overrides detect");
    expect_out(2 * W, 3'b110, 3'b111, "R7 lock kept");
    test_en = 1'b0;
    expect_out(5, 3'b001, 3'b111, "R6 test low restores detect");
    sig_det_a = 1'b1;
    expect_out(7 * W, 3'b100, 3'b101, "R8 relock after test");

    rate_hi = 1'b0;
    data_per = 1.0;
    expect_out(5, 3'b000, 3'b110, "R9 rate change drops lock");
    acquire(5, "R9 slow mode R2");

    data_per = 1.002;
    expect_out(3 * W, 3'b100, 3'b100, "R2 slow inside tolerance");
    data_per = 1.01;
    expect_out(2 * W, 3'b000, 3'b110, "R5 slow outside tolerance");
    data_per = 1.0;
    expect_out(7 * W, 3'b100, 3'b100, "R5 slow relock");

    data_per = 0.25;
    expect_out(2 * W, 3'b000, 3'b110, "R2 wrong rate drops lock");
    no_lock_for(8 * W, "R2 wrong rate never locks");
    data_per = 1.0;
    expect_out(7 * W, 3'b100, 3'b100, "R2 slow relock");

    rate_hi = 1'b1;
    data_per = 0.25;
    expect_out(5, 3'b000, 3'b110, "R9 back to fast drops lock");
    expect_out(7 * W, 3'b100, 3'b100, "R9 fast relock");

    cyc(3);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule